// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the functional clock into time quanta and sequences one nominal CAN bit through four segments in fixed order: synchronization, propagation, first phase and second phase. It emits a one-cycle strobe at the sample point and another at the end of every bit. The protocol engine of one channel uses the sample strobe to latch the bus level and the bit strobe to advance its bit counter.

Every segment length is held as a field value plus one. The timing fields can only be written while the channel is disabled and no bit is running. A recessive-to-dominant edge on the received level starts bit timing (hard synchronization). Later edges move the sample point and the bit end by a bounded amount (resynchronization). The bound is the jump width. A configuration whose total length falls outside 8 to 25 quanta is flagged and never runs. The same applies when the jump width exceeds either phase segment. Clearing the channel enable lets the current bit finish and then stops.

Top module: `can_bittime_gen`

## Requirements
- R1: One time quantum lasts `presc_cfg`+1 clock cycles. While a bit is running, `tq_tick` is high for the last clock cycle of each quantum.
- R2: A bit lasts 1 + (`prop_cfg`+1) + (`ph1_cfg`+1) + (`ph2_cfg`+1) quanta. `sample_stb` pulses for one cycle after the last quantum of phase segment 1. `bit_stb` pulses for one cycle after the last quantum of phase segment 2. The two never coincide.
- R3: `rx_lvl` is 1 for recessive and 0 for dominant. While idle and enabled, a 1-to-0 change of `rx_lvl` between two clock edges starts a bit. The clock cycle that sees the edge serves as the sync segment, and the propagation segment starts with a cleared prescaler.
- R4: An edge detected at a quantum boundary in the propagation segment or in phase segment 1 lengthens phase segment 1 by min(e, `sjw_cfg`+1). Here e is the number of quanta from the end of the sync segment up to and including the edge quantum.
- R5: An edge detected in phase segment 2 shortens that segment by min(r, `sjw_cfg`+1). Here r is the number of quanta of phase segment 2 still left after the edge quantum.
- R6: An edge in the sync segment changes no length. At most one resynchronization is applied per bit.
- R7: A write pulse on `cfg_we` has no effect while `chan_en` is high or a bit is in progress.
- R8: `cfg_bad` is high when the total bit length is below 8 or above 25 quanta, or when `sjw_cfg` exceeds `ph1_cfg` or `ph2_cfg`. While it is high, no bit is started and no strobe is produced.
- R9: When `chan_en` goes low, the bit in progress still completes with its strobes. No further bit starts until a new hard synchronization.
- R10: After reset all strobes are low. The configuration defaults to `presc_cfg`=0, `prop_cfg`=2, `ph1_cfg`=2, `ph2_cfg`=2, `sjw_cfg`=0, which gives a valid 10-quantum bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low stops timing after the current bit |
| rx_lvl | input | 1 | Received bus level, 1 = recessive |
| cfg_we | input | 1 | Configuration write strobe |
| presc_cfg | input | PRESC_W | Quantum prescaler field |
| prop_cfg | input | SEG_W | Propagation segment field |
| ph1_cfg | input | SEG_W | Phase segment 1 field |
| ph2_cfg | input | SEG_W | Phase segment 2 field |
| sjw_cfg | input | SJW_W | Jump width field |
| tq_tick | output | 1 | Last clock of a time quantum |
| sample_stb | output | 1 | Sample-point strobe |
| bit_stb | output | 1 | Bit-end strobe |
| cfg_bad | output | 1 | Held configuration is unusable |

## Verification
The assertions take for granted that the timing fields cannot move while a bit is running. This holds because the write lock covers both the enable and the busy state, so tick spacing and the quiet output under a bad configuration can be judged against the held fields alone. The received level is evaluated only at quantum boundaries. The stimulus therefore drops it to dominant for exactly one clock, with the prescaler at zero and a recessive cycle before each drop, so every intended edge lands in a known quantum. Each resynchronization test places one edge, or two for the one-per-bit rule, inside a single bit. It also keeps edges out of the quantum where the previous bit ends.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_PROP,
      ST_PH1,
      ST_PH2
   } seg_e;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
   parameter int PRESC_W = 6,
   parameter int SEG_W   = 3,
   parameter int SJW_W   = 2,
   parameter int MIN_TQ  = 8,
   parameter int MAX_TQ  = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock,
   input  logic               we,
   input  logic [PRESC_W-1:0] presc_in,
   input  logic [SEG_W-1:0]   prop_in,
   input  logic [SEG_W-1:0]   ph1_in,
   input  logic [SEG_W-1:0]   ph2_in,
   input  logic [SJW_W-1:0]   sjw_in,
   output logic [PRESC_W-1:0] presc_q,
   output logic [SEG_W-1:0]   prop_q,
   output logic [SEG_W-1:0]   ph1_q,
   output logic [SEG_W-1:0]   ph2_q,
   output logic [SJW_W-1:0]   sjw_q,
   output logic               bad
);
   localparam int TW    = SEG_W + 3;
   localparam int CMP_W = SEG_W + SJW_W;
   localparam logic [SEG_W-1:0] SEG_DEF = SEG_W'(2);

   logic [TW-1:0] total;
   logic          len_bad, jump_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         prop_q  <= SEG_DEF;
         ph1_q   <= SEG_DEF;
         ph2_q   <= SEG_DEF;
         sjw_q   <= '0;
      end else if (we && !lock) begin
         presc_q <= presc_in;
         prop_q  <= prop_in;
         ph1_q   <= ph1_in;
         ph2_q   <= ph2_in;
         sjw_q   <= sjw_in;
      end
   end

   // one sync quantum plus three segments each stored minus one
   assign total    = TW'(prop_q) + TW'(ph1_q) + TW'(ph2_q) + TW'(4);
   assign len_bad  = (total < TW'(MIN_TQ)) || (total > TW'(MAX_TQ));
   assign jump_bad = (CMP_W'(sjw_q) > CMP_W'(ph1_q)) || (CMP_W'(sjw_q) > CMP_W'(ph2_q));
   assign bad      = len_bad || jump_bad;
endmodule

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
   parameter int PRESC_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   logic [PRESC_W-1:0] pc;

   assign tick = run && (pc == presc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pc <= '0;
      else if (!run || tick) pc <= '0;
      else                   pc <= pc + 1'b1;
   end
endmodule

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign rx_out = rx_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], rx_in};
         end
         assign rx_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
   import cbt_pkg::*;
#(
   parameter int SEG_W = 3,
   parameter int SJW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             rx,
   input  logic [SEG_W-1:0] prop_f,
   input  logic [SEG_W-1:0] ph1_f,
   input  logic [SEG_W-1:0] ph2_f,
   input  logic [SJW_W-1:0] sjw_f,
   output logic             busy,
   output logic             sample_stb,
   output logic             bit_stb
);
   localparam int CW = SEG_W + 3;
   typedef logic [CW-1:0] cnt_t;

   seg_e st, st_d;
   cnt_t cnt, cnt_d, lim, lim_d, ext, ext_d, lim_n;
   cnt_t prop_len, ph1_len, ph2_len, sjw_len;
   logic rs, rs_d, rx_q, smp_d, bit_d, step, fall;

   function automatic cnt_t clip(input cnt_t e, input cnt_t j);
      return (e < j) ? e : j;
   endfunction

   assign prop_len = cnt_t'(prop_f) + cnt_t'(1);
   assign ph1_len  = cnt_t'(ph1_f) + cnt_t'(1);
   assign ph2_len  = cnt_t'(ph2_f) + cnt_t'(1);
   assign sjw_len  = cnt_t'(sjw_f) + cnt_t'(1);

   // idle watches the bus every clock; a running bit only at quantum ends
   assign step = (st == ST_IDLE) ? 1'b1 : tick;
   assign fall = step && rx_q && !rx;
   assign busy = (st != ST_IDLE);

   always_comb begin
      st_d  = st;
      cnt_d = cnt;
      lim_d = lim;
      ext_d = ext;
      rs_d  = rs;
      lim_n = lim;
      smp_d = 1'b0;
      bit_d = 1'b0;
      unique case (st)
         ST_IDLE: if (active && fall) begin
            st_d  = ST_PROP;
            cnt_d = '0;
            lim_d = prop_len - cnt_t'(1);
            ext_d = '0;
            rs_d  = 1'b0;
         end
         ST_SYNC: if (step) begin
            st_d  = ST_PROP;
            cnt_d = '0;
            lim_d = prop_len - cnt_t'(1);
         end
         ST_PROP: if (step) begin
            if (fall && !rs) begin
               ext_d = clip(cnt + cnt_t'(1), sjw_len);
               rs_d  = 1'b1;
            end
            if (cnt == lim) begin
               st_d  = ST_PH1;
               cnt_d = '0;
               lim_d = ph1_len - cnt_t'(1) + ext_d;
            end else begin
               cnt_d = cnt + cnt_t'(1);
            end
         end
         ST_PH1: if (step) begin
            if (fall && !rs) begin
               lim_n = lim + clip(prop_len + cnt + cnt_t'(1), sjw_len);
               rs_d  = 1'b1;
            end
            if (cnt == lim_n) begin
               st_d  = ST_PH2;
               cnt_d = '0;
               lim_d = ph2_len - cnt_t'(1);
               smp_d = 1'b1;
            end else begin
               cnt_d = cnt + cnt_t'(1);
               lim_d = lim_n;
            end
         end
         ST_PH2: if (step) begin
            if (fall && !rs) begin
               lim_n = lim - clip(lim - cnt, sjw_len);
               rs_d  = 1'b1;
            end
            if (cnt == lim_n) begin
               st_d  = active ? ST_SYNC : ST_IDLE;
               cnt_d = '0;
               ext_d = '0;
               rs_d  = 1'b0;
               bit_d = 1'b1;
            end else begin
               cnt_d = cnt + cnt_t'(1);
               lim_d = lim_n;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         lim        <= '0;
         ext        <= '0;
         rs         <= 1'b0;
         rx_q       <= 1'b1;
         sample_stb <= 1'b0;
         bit_stb    <= 1'b0;
      end else begin
         st         <= st_d;
         cnt        <= cnt_d;
         lim        <= lim_d;
         ext        <= ext_d;
         rs         <= rs_d;
         sample_stb <= smp_d;
         bit_stb    <= bit_d;
         if (step) rx_q <= rx;
      end
   end
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen #(
   parameter int PRESC_W        = 6,
   parameter int SEG_W          = 3,
   parameter int SJW_W          = 2,
   parameter int RX_SYNC_STAGES = 0,
   parameter int MIN_TQ         = 8,
   parameter int MAX_TQ         = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chan_en,
   input  logic               rx_lvl,
   input  logic               cfg_we,
   input  logic [PRESC_W-1:0] presc_cfg,
   input  logic [SEG_W-1:0]   prop_cfg,
   input  logic [SEG_W-1:0]   ph1_cfg,
   input  logic [SEG_W-1:0]   ph2_cfg,
   input  logic [SJW_W-1:0]   sjw_cfg,
   output logic               tq_tick,
   output logic               sample_stb,
   output logic               bit_stb,
   output logic               cfg_bad
);
   generate
      if (SJW_W > SEG_W || SEG_W < 1 || PRESC_W < 1) begin : g_bad_width
         $error("can_bittime_gen: field widths inconsistent");
      end
      if (MIN_TQ < 4 || MAX_TQ < MIN_TQ || RX_SYNC_STAGES == 1) begin : g_bad_range
         $error("can_bittime_gen: quantum range or synchronizer depth invalid");
      end
   endgenerate

   logic [PRESC_W-1:0] presc_q;
   logic [SEG_W-1:0]   prop_q, ph1_q, ph2_q;
   logic [SJW_W-1:0]   sjw_q;
   logic               busy, active, rx_s;

   assign active = chan_en && !cfg_bad;

   cbt_cfg_regs #(
      .PRESC_W(PRESC_W), .SEG_W(SEG_W), .SJW_W(SJW_W),
      .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .lock(chan_en || busy), .we(cfg_we),
      .presc_in(presc_cfg), .prop_in(prop_cfg), .ph1_in(ph1_cfg),
      .ph2_in(ph2_cfg), .sjw_in(sjw_cfg),
      .presc_q(presc_q), .prop_q(prop_q), .ph1_q(ph1_q),
      .ph2_q(ph2_q), .sjw_q(sjw_q), .bad(cfg_bad)
   );

   cbt_rx_sync #(.STAGES(RX_SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_lvl), .rx_out(rx_s)
   );

   cbt_tq_div #(.PRESC_W(PRESC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .presc(presc_q), .tick(tq_tick)
   );

   cbt_seg_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tq_tick), .rx(rx_s),
      .prop_f(prop_q), .ph1_f(ph1_q), .ph2_f(ph2_q), .sjw_f(sjw_q),
      .busy(busy), .sample_stb(sample_stb), .bit_stb(bit_stb)
   );
endmodule

// File: rtl/cbt_chk.sv
module cbt_chk #(
   parameter int CFG_W   = 17,
   parameter int PRESC_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               chan_en,
   input logic               busy,
   input logic               tq_tick,
   input logic               sample_stb,
   input logic               bit_stb,
   input logic               cfg_bad,
   input logic [CFG_W-1:0]   cfg_snap,
   input logic [PRESC_W-1:0] presc_q
);
   logic smp_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          smp_seen <= 1'b0;
      else if (bit_stb)    smp_seen <= 1'b0;
      else if (sample_stb) smp_seen <= 1'b1;
   end

   a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_stb, bit_stb}));

   a_r2_sample_before_end: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> smp_seen);

   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tq_tick && presc_q != '0) |=> !tq_tick);

   a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chan_en) || $past(busy)) |-> $stable(cfg_snap));

   a_r8_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |-> !(sample_stb || bit_stb || tq_tick));

   a_r9_stop_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !$past(chan_en)) |-> !busy);
endmodule

bind can_bittime_gen cbt_chk #(
   .CFG_W(PRESC_W + 3 * SEG_W + SJW_W),
   .PRESC_W(PRESC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .busy(busy),
   .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb),
   .cfg_bad(cfg_bad),
   .cfg_snap({presc_q, prop_q, ph1_q, ph2_q, sjw_q}),
   .presc_q(presc_q)
);

// File: tb/can_bittime_gen_tb.sv
module can_bittime_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_en = 1'b0;
   logic       rx_lvl = 1'b1;
   logic       cfg_we = 1'b0;
   logic [5:0] presc_cfg = '0;
   logic [2:0] prop_cfg = '0, ph1_cfg = '0, ph2_cfg = '0;
   logic [1:0] sjw_cfg = '0;
   logic       tq_tick, sample_stb, bit_stb, cfg_bad;

   int cyc = 0;
   int checks = 0;
   int errs = 0;
   bit finished = 1'b0;

   typedef struct {
      bit    is_bit;
      int    t;
      string tag;
   } ev_t;
   ev_t evq[$];

   can_bittime_gen u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_lvl(rx_lvl),
      .cfg_we(cfg_we), .presc_cfg(presc_cfg), .prop_cfg(prop_cfg),
      .ph1_cfg(ph1_cfg), .ph2_cfg(ph2_cfg), .sjw_cfg(sjw_cfg),
      .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb),
      .cfg_bad(cfg_bad)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_ev(input bit is_bit, input int t, input string tag);
      ev_t e;
      e.is_bit = is_bit;
      e.t      = t;
      e.tag    = tag;
      evq.push_back(e);
   endtask

   // monitor: compare each produced strobe with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && (sample_stb || bit_stb)) begin
         checks++;
         if (evq.size() == 0) begin
            errs++;
            $display("FAIL unexpected: actual sample=%0d bit=%0d at cycle %0d, expected none",
                     sample_stb, bit_stb, cyc);
         end else begin
            ev_t e;
            e = evq.pop_front();
            if (sample_stb == bit_stb || bit_stb != e.is_bit || cyc != e.t) begin
               errs++;
               $display("FAIL %s: actual bit=%0d at cycle %0d, expected bit=%0d at cycle %0d",
                        e.tag, bit_stb, cyc, e.is_bit, e.t);
            end
         end
      end
   end

   task automatic at_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // dominant for one clock so the falling edge is seen at posedge t
   task automatic pulse(input int t);
      at_cyc(t - 1);
      rx_lvl = 1'b0;
      @(negedge clk);
      rx_lvl = 1'b1;
   endtask

   task automatic write_cfg(input int pr, input int pp, input int p1, input int p2, input int sj);
      presc_cfg = 6'(pr);
      prop_cfg  = 3'(pp);
      ph1_cfg   = 3'(p1);
      ph2_cfg   = 3'(p2);
      sjw_cfg   = 2'(sj);
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic drain(input string tag);
      chk(evq.size() == 0, tag, evq.size(), 0);
      evq.delete();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int e0, ticks;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!sample_stb && !bit_stb && !tq_tick, "R10 strobes idle", {sample_stb, bit_stb, tq_tick}, 0);
      chk(cfg_bad == 1'b0, "R10 default config valid", cfg_bad, 0);

      // prescaler 3 clocks, lengths 2/3/2, bit of 8 quanta
      write_cfg(2, 1, 2, 1, 0);
      chan_en = 1'b1;
      @(negedge clk);
      rx_lvl = 1'b0;
      e0 = cyc + 1;
      expect_ev(1'b0, e0 + 15, "R3 hard sync sample");
      expect_ev(1'b1, e0 + 21, "R3 hard sync bit end");
      expect_ev(1'b0, e0 + 39, "R2 sample with prescaler");
      expect_ev(1'b1, e0 + 45, "R9 bit finishes after disable");
      @(negedge clk);
      rx_lvl = 1'b1;
      ticks = 0;
      for (int i = 0; i < 24; i++) begin
         if (tq_tick) ticks++;
         @(negedge clk);
      end
      chk(ticks == 8, "R1 quanta of three clocks", ticks, 8);
      at_cyc(e0 + 40);
      chan_en = 1'b0;
      at_cyc(e0 + 80);
      drain("R9 no bit after disable");

      // prescaler 1, lengths 3/3/3, jump width 2
      write_cfg(0, 2, 2, 2, 1);
      chan_en = 1'b1;
      @(negedge clk);
      rx_lvl = 1'b0;
      e0 = cyc + 1;
      @(negedge clk);
      rx_lvl = 1'b1;
      expect_ev(1'b0, e0 + 6,  "R2 first sample");
      expect_ev(1'b1, e0 + 9,  "R2 first bit end");
      expect_ev(1'b0, e0 + 17, "R4 propagation edge lengthens sample");
      expect_ev(1'b1, e0 + 20, "R4 propagation edge lengthens bit");
      expect_ev(1'b0, e0 + 29, "R4 phase1 edge clamped by jump width");
      expect_ev(1'b1, e0 + 32, "R4 phase1 edge bit end");
      expect_ev(1'b0, e0 + 39, "R6 sync edge sample unchanged");
      expect_ev(1'b1, e0 + 42, "R6 sync edge bit unchanged");
      expect_ev(1'b0, e0 + 49, "R5 sample before early edge");
      expect_ev(1'b1, e0 + 50, "R5 phase2 shortened");
      expect_ev(1'b0, e0 + 58, "R6 second edge ignored sample");
      expect_ev(1'b1, e0 + 61, "R6 second edge ignored bit");
      expect_ev(1'b0, e0 + 68, "R7 locked write sample");
      expect_ev(1'b1, e0 + 71, "R7 locked write bit");
      expect_ev(1'b0, e0 + 78, "R7 locked write next sample");
      expect_ev(1'b1, e0 + 81, "R7 locked write next bit");
      expect_ev(1'b0, e0 + 88, "R9 running bit sample");
      expect_ev(1'b1, e0 + 91, "R9 running bit completes");
      pulse(e0 + 11);
      pulse(e0 + 26);
      pulse(e0 + 33);
      pulse(e0 + 50);
      pulse(e0 + 52);
      pulse(e0 + 55);
      at_cyc(e0 + 63);
      write_cfg(3, 7, 7, 7, 0);
      at_cyc(e0 + 84);
      chan_en = 1'b0;
      at_cyc(e0 + 130);
      drain("R9 idle after disable");

      // R8 validity
      write_cfg(0, 0, 0, 0, 0);
      chk(cfg_bad == 1'b1, "R8 four quanta rejected", cfg_bad, 1);
      chan_en = 1'b1;
      pulse(cyc + 3);
      at_cyc(cyc + 30);
      drain("R8 no timing when bad");
      chan_en = 1'b0;
      @(negedge clk);
      write_cfg(0, 7, 7, 7, 0);
      chk(cfg_bad == 1'b0, "R8 25 quanta accepted", cfg_bad, 0);
      write_cfg(0, 1, 1, 2, 0);
      chk(cfg_bad == 1'b0, "R8 8 quanta accepted", cfg_bad, 0);
      write_cfg(0, 1, 1, 1, 0);
      chk(cfg_bad == 1'b1, "R8 7 quanta rejected", cfg_bad, 1);
      write_cfg(0, 7, 3, 1, 3);
      chk(cfg_bad == 1'b1, "R8 jump width above phase2", cfg_bad, 1);
      write_cfg(0, 7, 3, 3, 3);
      chk(cfg_bad == 1'b0, "R8 jump width equal phases", cfg_bad, 0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule